// File: doc/BRIEF.md
# Sample-Rate Path and Mute Controller

This controller sits beside a 2x oversampling decoder and decides which path the audio takes to the output transmitter. When the incoming stream runs faster than 48 kHz, the decoder is bypassed and the transmitter runs at a 256x clock ratio. At 48 kHz or below, the decoder's FIFO output is used and the ratio is 128x. Every change of rate class moves the path mux and the clock-ratio select together. A fixed-length reset pulse follows one cycle later. The pulse goes to the transmitter in both directions, and also to the FIFO when the path returns to it.

The controller also owns the user settings: which of two inputs is selected, and a scale bit kept separately for each input. These three bits are restored from a nonvolatile image in the first cycle after reset. Any later change raises a one-cycle save strobe so that external logic can write them back. The decoder's hard mute is driven from every condition that could produce a glitch:
- a button press, which mutes for a fixed window;
- loss of receiver lock;
- a high input rate;
- a rate-class switch that is still in progress.

Front-panel indicators mirror the settings and the status.

Top module: `rate_path_ctrl`

## Requirements
- R1: In the first clock cycle after reset release, the persistent bits are loaded from `nv_image_i`, with bit 0 = selected channel, bit 1 = scale of channel 0 and bit 2 = scale of channel 1. `nv_image_o` then equals that image, and `save_o` stays low. `mute_o` is high while reset is asserted.
- R2: A channel press (`chan_btn_i` high for one cycle) inverts `chan_sel_o` from the next cycle on.
- R3: A scale press inverts only the scale bit of the channel selected before the press. The other channel's scale bit is unchanged. `scale_o` always shows the scale bit of the currently selected channel. A press of both buttons in the same cycle applies both rules.
- R4: `save_o` is high for exactly the one cycle after any press that changes the persistent bits. It is never raised by the power-on load.
- R5: When `rate_hi_i` rises while no switch is in progress, `bypass_o` and `ratio_256_o` both go high in the next cycle. `tx_rst_o` starts one cycle after that and stays high for exactly `RST_CYCLES` cycles, and `fifo_rst_o` stays low.
- R6: When `rate_hi_i` falls while no switch is in progress, `bypass_o` and `ratio_256_o` both go low in the next cycle. One cycle later, `tx_rst_o` and `fifo_rst_o` are high together for exactly `RST_CYCLES` cycles.
- R7: While a switch sequence runs, the path outputs hold their value. A rate flag that differs from the current path once the pulse has ended starts a new switch.
- R8: `mute_o` is high in any cycle where `lock_i` is low, where `rate_hi_i` is high, or while the bypass path is selected.
- R9: A button press keeps `mute_o` high for exactly `BTN_MUTE_CYCLES` cycles, starting in the cycle after the press.
- R10: From a rate-class switch until its reset pulse has ended and `lock_i` is high, `mute_o` stays high.
- R11: The indicators work as follows:
  - `led_chan_o` follows `chan_sel_o` and `led_scale_o` follows `scale_o`.
  - `led_err_o` is high when lock is lost.
  - `led_hi_o` follows `bypass_o`.
  - `led_dec_o` is `dec_active_i` gated by lock and by the FIFO path being selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Receiver lock |
| rate_hi_i | input | 1 | Input rate above 48 kHz |
| chan_btn_i | input | 1 | Debounced channel press, one cycle |
| scale_btn_i | input | 1 | Debounced scale press, one cycle |
| dec_active_i | input | 1 | Decoder reports encoded material |
| nv_image_i | input | 3 | Stored settings image |
| nv_image_o | output | 3 | Current settings image |
| save_o | output | 1 | Settings changed strobe |
| chan_sel_o | output | 1 | Input channel select |
| scale_o | output | 1 | Decoder scale control |
| bypass_o | output | 1 | Path mux: 1 = bypass decoder |
| ratio_256_o | output | 1 | Transmitter ratio: 1 = 256x, 0 = 128x |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| fifo_rst_o | output | 1 | FIFO reset pulse |
| mute_o | output | 1 | Decoder hard mute |
| led_chan_o | output | 1 | Channel indicator |
| led_scale_o | output | 1 | Scale indicator |
| led_err_o | output | 1 | Error indicator |
| led_dec_o | output | 1 | Decoder active indicator |
| led_hi_o | output | 1 | Above-48k indicator |

## Verification
The bench builds the block with `RST_CYCLES = 4` and `BTN_MUTE_CYCLES = 8`. These values let every reset pulse and every button mute window be counted cycle by cycle to its exact end. They also make it cheap to sweep all eight stored images against all three button combinations. The short pulse also allows a rate flip to land inside a running sequence, and lock loss to span the end of a pulse.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_PULSE  = 2'd2
  } seq_state_e;

  // bit 0 channel, bit 1 scale ch0, bit 2 scale ch1
  typedef struct packed {
    logic [1:0] scale;
    logic       chan;
  } nv_bits_t;

  localparam int unsigned NV_W = $bits(nv_bits_t);
endpackage

// File: rtl/rpc_persist.sv
module rpc_persist
  import rpc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     chan_btn_i,
  input  logic     scale_btn_i,
  input  nv_bits_t nv_image_i,
  output nv_bits_t bits_o,
  output logic     loaded_o,
  output logic     press_o,
  output logic     save_o
);
  nv_bits_t bits_q, bits_d;
  logic     loaded_q, save_q;

  assign press_o = loaded_q & (chan_btn_i | scale_btn_i);

  always_comb begin
    bits_d = bits_q;
    if (scale_btn_i) bits_d.scale[bits_q.chan] = ~bits_q.scale[bits_q.chan];
    if (chan_btn_i)  bits_d.chan = ~bits_q.chan;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q   <= '0;
      loaded_q <= 1'b0;
      save_q   <= 1'b0;
    end else if (!loaded_q) begin
      bits_q   <= nv_image_i;
      loaded_q <= 1'b1;
      save_q   <= 1'b0;
    end else begin
      bits_q   <= bits_d;
      save_q   <= press_o;
    end
  end

  assign bits_o   = bits_q;
  assign loaded_o = loaded_q;
  assign save_o   = save_q;

  AST_SAVE_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(loaded_q) && !$stable(bits_q)) |-> save_q); // R4
  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_q) |-> !save_q); // R1
  AST_SCALE_ONE_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && scale_btn_i && !chan_btn_i) |=>
      ($countones(bits_q ^ $past(bits_q)) == 1)); // R3
endmodule

// File: rtl/rpc_rate_seq.sv
module rpc_rate_seq
  import rpc_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_hi_i,
  output logic rate_cls_o,
  output logic tx_rst_o,
  output logic fifo_rst_o,
  output logic busy_o
);
  localparam int unsigned CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam int unsigned PW = $clog2(RST_CYCLES + 2);

  seq_state_e    state_q;
  logic          cls_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cls_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (rate_hi_i != cls_q) begin
          cls_q   <= rate_hi_i;   // mux and ratio flip together
          state_q <= SEQ_SETTLE;
        end
        SEQ_SETTLE: begin
          cnt_q   <= CW'(RST_CYCLES - 1);
          state_q <= SEQ_PULSE;
        end
        SEQ_PULSE: if (cnt_q == '0) state_q <= SEQ_IDLE;
                   else cnt_q <= cnt_q - 1'b1;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rate_cls_o = cls_q;
  assign tx_rst_o   = (state_q == SEQ_PULSE);
  assign fifo_rst_o = (state_q == SEQ_PULSE) & ~cls_q;
  assign busy_o     = (state_q != SEQ_IDLE);

  // pulse length monitor
  logic [PW-1:0] plen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       plen_q <= '0;
    else if (tx_rst_o) plen_q <= plen_q + 1'b1;
    else               plen_q <= '0;
  end

  AST_RST_AFTER_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cls_q) |=> tx_rst_o); // R5
  AST_RST_LEN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plen_q <= PW'(RST_CYCLES)); // R5
  AST_RST_LEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_rst_o) |-> (plen_q == PW'(RST_CYCLES))); // R6
  AST_FIFO_RST_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |-> (tx_rst_o && !cls_q)); // R6
  AST_PATH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_o |=> $stable(cls_q)); // R7
endmodule

// File: rtl/rpc_mute.sv
module rpc_mute #(
  parameter int unsigned BTN_MUTE_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic press_i,
  input  logic loaded_i,
  input  logic lock_i,
  input  logic rate_hi_i,
  input  logic rate_cls_i,
  input  logic busy_i,
  output logic mute_o
);
  localparam int unsigned TW = $clog2(BTN_MUTE_CYCLES + 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tmr_q <= '0;
    else if (press_i)      tmr_q <= TW'(BTN_MUTE_CYCLES);
    else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  assign mute_o = ~loaded_i | ~lock_i | rate_hi_i | rate_cls_i | busy_i
                | (tmr_q != '0);

  AST_BTN_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i |=> mute_o); // R9
  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= TW'(BTN_MUTE_CYCLES)); // R9
endmodule

// File: rtl/rate_path_ctrl.sv
module rate_path_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned RST_CYCLES      = 16,
  parameter int unsigned BTN_MUTE_CYCLES = 4096
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic            rate_hi_i,
  input  logic            chan_btn_i,
  input  logic            scale_btn_i,
  input  logic            dec_active_i,
  input  logic [NV_W-1:0] nv_image_i,
  output logic [NV_W-1:0] nv_image_o,
  output logic            save_o,
  output logic            chan_sel_o,
  output logic            scale_o,
  output logic            bypass_o,
  output logic            ratio_256_o,
  output logic            tx_rst_o,
  output logic            fifo_rst_o,
  output logic            mute_o,
  output logic            led_chan_o,
  output logic            led_scale_o,
  output logic            led_err_o,
  output logic            led_dec_o,
  output logic            led_hi_o
);
  nv_bits_t bits;
  logic     loaded, press, rate_cls, busy;

  rpc_persist i_persist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_btn_i  (chan_btn_i),
    .scale_btn_i (scale_btn_i),
    .nv_image_i  (nv_bits_t'(nv_image_i)),
    .bits_o      (bits),
    .loaded_o    (loaded),
    .press_o     (press),
    .save_o      (save_o)
  );

  rpc_rate_seq #(.RST_CYCLES(RST_CYCLES)) i_rate_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_hi_i  (rate_hi_i),
    .rate_cls_o (rate_cls),
    .tx_rst_o   (tx_rst_o),
    .fifo_rst_o (fifo_rst_o),
    .busy_o     (busy)
  );

  rpc_mute #(.BTN_MUTE_CYCLES(BTN_MUTE_CYCLES)) i_mute (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .press_i    (press),
    .loaded_i   (loaded),
    .lock_i     (lock_i),
    .rate_hi_i  (rate_hi_i),
    .rate_cls_i (rate_cls),
    .busy_i     (busy),
    .mute_o     (mute_o)
  );

  assign nv_image_o  = bits;
  assign chan_sel_o  = bits.chan;
  assign scale_o     = bits.scale[bits.chan];
  assign bypass_o    = rate_cls;
  assign ratio_256_o = rate_cls;

  assign led_chan_o  = bits.chan;
  assign led_scale_o = bits.scale[bits.chan];
  assign led_err_o   = ~lock_i;
  assign led_hi_o    = rate_cls;
  assign led_dec_o   = dec_active_i & lock_i & ~rate_cls;

  AST_RST_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_o |-> mute_o); // R10
  AST_BYPASS_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> mute_o); // R8
  AST_RATIO_WITH_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bypass_o) |-> !$stable(ratio_256_o)); // R5
endmodule

// File: tb/test_rate_path_ctrl.sv
`timescale 1ns/1ps
module test_rate_path_ctrl;
  localparam int RC = 4;
  localparam int BM = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lock_i = 1'b1, rate_hi_i = 1'b0, chan_btn_i = 1'b0, scale_btn_i = 1'b0;
  logic dec_active_i = 1'b0;
  logic [2:0] nv_image_i = '0;
  logic [2:0] nv_image_o;
  logic save_o, chan_sel_o, scale_o, bypass_o, ratio_256_o, tx_rst_o, fifo_rst_o, mute_o;
  logic led_chan_o, led_scale_o, led_err_o, led_dec_o, led_hi_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  rate_path_ctrl #(.RST_CYCLES(RC), .BTN_MUTE_CYCLES(BM)) i_rate_path_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i), .rate_hi_i(rate_hi_i),
    .chan_btn_i(chan_btn_i), .scale_btn_i(scale_btn_i), .dec_active_i(dec_active_i),
    .nv_image_i(nv_image_i), .nv_image_o(nv_image_o), .save_o(save_o),
    .chan_sel_o(chan_sel_o), .scale_o(scale_o), .bypass_o(bypass_o),
    .ratio_256_o(ratio_256_o), .tx_rst_o(tx_rst_o), .fifo_rst_o(fifo_rst_o),
    .mute_o(mute_o), .led_chan_o(led_chan_o), .led_scale_o(led_scale_o),
    .led_err_o(led_err_o), .led_dec_o(led_dec_o), .led_hi_o(led_hi_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] nv);
    rst_ni = 1'b0; nv_image_i = nv; chan_btn_i = 0; scale_btn_i = 0;
    lock_i = 1'b1; rate_hi_i = 1'b0;
    repeat (2) tick();
    check("R1 mute in reset", mute_o, 1);
    check("R1 save in reset", save_o, 0);
    rst_ni = 1'b1;
    tick();
    check("R1 image loaded", nv_image_o, nv);
    check("R1 channel", chan_sel_o, nv[0]);
    check("R1 scale", scale_o, nv[1 + nv[0]]);
    check("R1 no save on load", save_o, 0);
    check("R1 unmuted after load", mute_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt, cnt_f;
    logic [2:0] e;
    tick();
    // R1..R4, R9, R11: all images x all button combinations
    for (int nv = 0; nv < 8; nv++) begin
      for (int b = 1; b < 4; b++) begin
        do_reset(3'(nv));
        e = 3'(nv);
        if (b[1]) e[1 + e[0]] = ~e[1 + e[0]];
        if (b[0]) e[0] = ~e[0];
        chan_btn_i = b[0]; scale_btn_i = b[1];
        tick();
        chan_btn_i = 0; scale_btn_i = 0;
        check("R2 R3 image after press", nv_image_o, e);
        check("R2 channel", chan_sel_o, e[0]);
        check("R3 scale of selected", scale_o, e[1 + e[0]]);
        check("R4 save strobe", save_o, 1);
        check("R11 led_chan", led_chan_o, e[0]);
        check("R11 led_scale", led_scale_o, e[1 + e[0]]);
        cnt = 0;
        for (int i = 0; i < BM + 4; i++) begin
          if (mute_o) cnt++;
          tick();
          if (i == 0) check("R4 save one cycle", save_o, 0);
        end
        check("R9 button mute length", cnt, BM);
      end
    end

    // R8: immediate mute
    do_reset(3'b000);
    lock_i = 0; #1;
    check("R8 mute on lock loss", mute_o, 1);
    check("R11 led_err", led_err_o, 1);
    lock_i = 1; dec_active_i = 1; #1;
    check("R8 unmute with lock", mute_o, 0);
    check("R11 led_dec on fifo path", led_dec_o, 1);

    // R5: rise
    rate_hi_i = 1; #1;
    check("R8 mute on high rate", mute_o, 1);
    check("R5 path not yet switched", bypass_o, 0);
    tick();
    check("R5 bypass", bypass_o, 1);
    check("R5 ratio 256", ratio_256_o, 1);
    check("R5 settle cycle no reset", tx_rst_o, 0);
    check("R11 led_hi", led_hi_o, 1);
    check("R11 led_dec off in bypass", led_dec_o, 0);
    cnt = 0; cnt_f = 0;
    for (int i = 0; i < RC + 4; i++) begin
      tick();
      if (i == 0) check("R5 reset starts", tx_rst_o, 1);
      if (tx_rst_o) cnt++;
      if (fifo_rst_o) cnt_f++;
    end
    check("R5 tx reset length", cnt, RC);
    check("R5 no fifo reset", cnt_f, 0);

    // R6 + R10: fall with lock loss across the pulse
    rate_hi_i = 0; lock_i = 0;
    tick();
    check("R6 bypass off", bypass_o, 0);
    check("R6 ratio 128", ratio_256_o, 0);
    check("R10 mute during switch", mute_o, 1);
    cnt = 0; cnt_f = 0;
    for (int i = 0; i < RC + 3; i++) begin
      tick();
      if (tx_rst_o) cnt++;
      if (tx_rst_o && fifo_rst_o) cnt_f++;
      if (tx_rst_o && !mute_o) check("R10 muted in pulse", 0, 1);
    end
    check("R6 tx reset length", cnt, RC);
    check("R6 fifo reset with tx", cnt_f, RC);
    check("R10 mute held until relock", mute_o, 1);
    lock_i = 1;
    tick();
    check("R10 unmute after relock", mute_o, 0);

    // R7: flip back during pulse
    rate_hi_i = 1;
    tick();
    tick();
    rate_hi_i = 0;
    tick();
    check("R7 path held in pulse", bypass_o, 1);
    repeat (RC - 1) tick();
    check("R7 held until pulse end", bypass_o, 1);
    check("R7 pulse ended", tx_rst_o, 0);
    tick();
    check("R7 pending switch applied", bypass_o, 0);
    cnt_f = 0;
    for (int i = 0; i < RC + 3; i++) begin
      tick();
      if (fifo_rst_o) cnt_f++;
    end
    check("R7 second pulse fifo reset", cnt_f, RC);
    check("R10 mute clear at end", mute_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule